// File: doc/BRIEF.md
# LCD Parallel Bus Master (Dual Signalling Style)

This block moves single bytes between a host and a character or graphic LCD module over a parallel bus. The host raises a request carrying a direction (write or read), a register-select flag and a byte. The block then runs one complete bus transaction and answers with a one-clock done pulse. On a read, the byte taken from the module comes back with that pulse.

A static style input picks between two signalling schemes. The first uses one enable strobe plus a direction level. The second uses separate active-low write and read strobes. A second static input selects nibble mode. In that mode each byte travels as two strobe beats on the upper four data lines, high nibble first.

Each beat has three timed phases: address setup, strobe pulse and hold. Each phase lasts a number of system clocks given by its own count input.

Top module: `lcd_pbus_master`

## Requirements
- R1: With `mode_6800`=1 the enable `lcd_e` is the strobe, `lcd_rw` is 1 for a read and 0 for a write during a transfer, and `lcd_wr_n`/`lcd_rd_n` stay 1. With `mode_6800`=0, `lcd_wr_n` (writes) or `lcd_rd_n` (reads) is the active-low strobe, `lcd_e` stays 0 and `lcd_rw` stays 1. At most one strobe is ever active.
- R2: `lcd_rs` equals the request's `req_rs` (0 = instruction, 1 = display data) in every clock that `lcd_cs_n` is low, so it is steady before the strobe asserts.
- R3: `lcd_cs_n` is low only in the setup, pulse and hold phases of a transfer. It is high while idle and in the done clock.
- R4: Every beat spends exactly max(`t_setup`,1) clocks in setup, max(`t_pulse`,1) clocks with the strobe active, and max(`t_hold`,1) clocks in hold. A count of 0 is treated as 1.
- R5: In 8-bit mode a write drives the whole byte on `lcd_db_o[7:0]` with `lcd_db_oe`=1 while the strobe is active.
- R6: In nibble mode a transfer has two beats. A write drives bits 7:4 of the byte on `lcd_db_o[7:4]` in the first beat and bits 3:0 in the second, with `lcd_db_o[3:0]`=0.
- R7: A read samples `lcd_db_i` in the last clock the strobe is active. In 8-bit mode `rsp_rdata` is that byte. In nibble mode the first beat's `lcd_db_i[7:4]` becomes bits 7:4 and the second beat's becomes bits 3:0. `rsp_rdata` is valid with `rsp_done`.
- R8: `lcd_db_oe` is 1 only for writes, from the first setup clock through the first hold clock of each beat. It is released one clock after the strobe ends, and `lcd_db_o` is 0 whenever `lcd_db_oe` is 0.
- R9: `rsp_done` is a single-clock pulse in the clock after the final hold clock, that is B*(S+P+H)+1 clocks after acceptance (B beats). `req_ready` is 1 only when idle. A `req_valid` raised during a transfer is ignored and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_6800 | input | 1 | 1: enable + direction style, 0: separate strobes style |
| nibble_mode | input | 1 | 1: two 4-bit beats per byte on lines 7:4 |
| t_setup | input | CNT_W | Setup phase length in clocks |
| t_pulse | input | CNT_W | Strobe phase length in clocks |
| t_hold | input | CNT_W | Hold phase length in clocks |
| req_valid | input | 1 | Host request |
| req_ready | output | 1 | Engine idle, request accepted this clock if valid |
| req_read | input | 1 | 1 = read, 0 = write |
| req_rs | input | 1 | Register-select value for the transfer |
| req_wdata | input | 8 | Byte to write |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Byte read from the module |
| lcd_cs_n | output | 1 | Active-low chip select |
| lcd_rs | output | 1 | Register select |
| lcd_e | output | 1 | Enable strobe (enable style) |
| lcd_rw | output | 1 | Direction level (enable style) |
| lcd_wr_n | output | 1 | Active-low write strobe (separate-strobe style) |
| lcd_rd_n | output | 1 | Active-low read strobe (separate-strobe style) |
| lcd_db_o | output | 8 | Data bus output value |
| lcd_db_oe | output | 1 | Data bus output enable |
| lcd_db_i | input | 8 | Data bus input value |

## Verification
With request acceptance at clock edge k, setup fills edges k+1..k+S, the strobe the next P edges, hold the next H, and `rsp_done` appears exactly B*(S+P+H)+1 edges after k. The bench drives requests and the module's read data on falling edges. It records every bus pin on each falling edge after acceptance and counts, per transfer, the clocks with chip select low, with strobe active and with output enable high. It also notes the index of the first strobe clock and of the done pulse, and compares each to the closed-form value from the phase counts. Read data is changed to the second nibble only on a falling edge after the first strobe has ended, so the sampled value in the last strobe clock is unambiguous.

// File: rtl/lcd_pbus_pkg.sv
package lcd_pbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_PULSE = 3'd2,
        PH_HOLD  = 3'd3,
        PH_FIN   = 3'd4
    } phase_e;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;

endpackage

// File: rtl/lcd_phase_len.sv
module lcd_phase_len
    import lcd_pbus_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  phase_e           phase,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] t_setup,
    input  logic [CNT_W-1:0] t_pulse,
    input  logic [CNT_W-1:0] t_hold,
    output logic             last
);
    logic [CNT_W-1:0] raw_len;
    logic [CNT_W-1:0] eff_len;

    always_comb begin
        unique case (phase)
            PH_SETUP: raw_len = t_setup;
            PH_PULSE: raw_len = t_pulse;
            PH_HOLD:  raw_len = t_hold;
            default:  raw_len = '0;
        endcase
        // zero counts behave as one clock
        eff_len = (raw_len == '0) ? CNT_W'(1) : raw_len;
        last    = (cnt == eff_len - CNT_W'(1));
    end
endmodule

// File: rtl/lcd_pin_decode.sv
module lcd_pin_decode
    import lcd_pbus_pkg::*;
(
    input  phase_e phase,
    input  logic   mode_6800,
    input  logic   is_read,
    output logic   cs_n,
    output logic   e,
    output logic   rw,
    output logic   wr_n,
    output logic   rd_n,
    output logic   strobe
);
    logic active;

    always_comb begin
        active = (phase == PH_SETUP) || (phase == PH_PULSE) || (phase == PH_HOLD);
        strobe = (phase == PH_PULSE);
        cs_n   = !active;
        if (mode_6800) begin
            e    = strobe;
            rw   = active ? is_read : 1'b1;
            wr_n = 1'b1;
            rd_n = 1'b1;
        end else begin
            e    = 1'b0;
            rw   = 1'b1;
            wr_n = !(strobe && !is_read);
            rd_n = !(strobe && is_read);
        end
    end
endmodule

// File: rtl/lcd_lane_mux.sv
module lcd_lane_mux
    import lcd_pbus_pkg::*;
(
    input  logic              nibble,
    input  logic              beat,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] db_in,
    input  logic [BYTE_W-1:0] rdata_old,
    output logic [BYTE_W-1:0] lane_out,
    output logic [BYTE_W-1:0] rdata_new
);
    logic [NIB_W-1:0] wr_nib;

    always_comb begin
        wr_nib = beat ? wdata[NIB_W-1:0] : wdata[BYTE_W-1:NIB_W];
        if (nibble) begin
            lane_out = {wr_nib, {NIB_W{1'b0}}};
            if (beat)
                rdata_new = {rdata_old[BYTE_W-1:NIB_W], db_in[BYTE_W-1:NIB_W]};
            else
                rdata_new = {db_in[BYTE_W-1:NIB_W], rdata_old[NIB_W-1:0]};
        end else begin
            lane_out  = wdata;
            rdata_new = db_in;
        end
    end
endmodule

// File: rtl/lcd_pbus_master.sv
module lcd_pbus_master
    import lcd_pbus_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_6800,
    input  logic             nibble_mode,
    input  logic [CNT_W-1:0] t_setup,
    input  logic [CNT_W-1:0] t_pulse,
    input  logic [CNT_W-1:0] t_hold,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_read,
    input  logic             req_rs,
    input  logic [7:0]       req_wdata,
    output logic             rsp_done,
    output logic [7:0]       rsp_rdata,
    output logic             lcd_cs_n,
    output logic             lcd_rs,
    output logic             lcd_e,
    output logic             lcd_rw,
    output logic             lcd_wr_n,
    output logic             lcd_rd_n,
    output logic [7:0]       lcd_db_o,
    output logic             lcd_db_oe,
    input  logic [7:0]       lcd_db_i
);
    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic              beat;
        logic              nib;
        logic              rd;
        logic              rs;
        logic [BYTE_W-1:0] wdata;
        logic [BYTE_W-1:0] rdata;
    } eng_t;

    eng_t eng_d, eng_q;

    logic              ph_last;
    logic              strobe;
    logic [BYTE_W-1:0] lane_out;
    logic [BYTE_W-1:0] rdata_new;

    lcd_phase_len #(.CNT_W(CNT_W)) u_len (
        .phase   (eng_q.phase),
        .cnt     (eng_q.cnt),
        .t_setup (t_setup),
        .t_pulse (t_pulse),
        .t_hold  (t_hold),
        .last    (ph_last)
    );

    lcd_pin_decode u_pins (
        .phase     (eng_q.phase),
        .mode_6800 (mode_6800),
        .is_read   (eng_q.rd),
        .cs_n      (lcd_cs_n),
        .e         (lcd_e),
        .rw        (lcd_rw),
        .wr_n      (lcd_wr_n),
        .rd_n      (lcd_rd_n),
        .strobe    (strobe)
    );

    lcd_lane_mux u_lane (
        .nibble    (eng_q.nib),
        .beat      (eng_q.beat),
        .wdata     (eng_q.wdata),
        .db_in     (lcd_db_i),
        .rdata_old (eng_q.rdata),
        .lane_out  (lane_out),
        .rdata_new (rdata_new)
    );

    always_comb begin
        eng_d = eng_q;
        unique case (eng_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    eng_d.phase = PH_SETUP;
                    eng_d.cnt   = '0;
                    eng_d.beat  = 1'b0;
                    eng_d.nib   = nibble_mode;
                    eng_d.rd    = req_read;
                    eng_d.rs    = req_rs;
                    eng_d.wdata = req_wdata;
                end
            end
            PH_SETUP: begin
                if (ph_last) begin
                    eng_d.phase = PH_PULSE;
                    eng_d.cnt   = '0;
                end else begin
                    eng_d.cnt = eng_q.cnt + CNT_W'(1);
                end
            end
            PH_PULSE: begin
                if (ph_last) begin
                    eng_d.phase = PH_HOLD;
                    eng_d.cnt   = '0;
                    // capture in the final strobe clock
                    if (eng_q.rd) eng_d.rdata = rdata_new;
                end else begin
                    eng_d.cnt = eng_q.cnt + CNT_W'(1);
                end
            end
            PH_HOLD: begin
                if (ph_last) begin
                    eng_d.cnt = '0;
                    if (eng_q.nib && !eng_q.beat) begin
                        eng_d.phase = PH_SETUP;
                        eng_d.beat  = 1'b1;
                    end else begin
                        eng_d.phase = PH_FIN;
                    end
                end else begin
                    eng_d.cnt = eng_q.cnt + CNT_W'(1);
                end
            end
            PH_FIN: begin
                eng_d.phase = PH_IDLE;
            end
            default: begin
                eng_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{phase: PH_IDLE, cnt: '0, beat: 1'b0, nib: 1'b0,
                       rd: 1'b0, rs: 1'b0, wdata: '0, rdata: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    always_comb begin
        req_ready = (eng_q.phase == PH_IDLE);
        rsp_done  = (eng_q.phase == PH_FIN);
        rsp_rdata = eng_q.rdata;
        lcd_rs    = eng_q.rs;
        lcd_db_oe = !eng_q.rd &&
                    ((eng_q.phase == PH_SETUP) || strobe ||
                     ((eng_q.phase == PH_HOLD) && (eng_q.cnt == '0)));
        lcd_db_o  = lcd_db_oe ? lane_out : '0;
    end
endmodule

// File: rtl/lcd_pbus_master_chk.sv
module lcd_pbus_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_6800,
    input logic       nibble_mode,
    input logic       req_ready,
    input logic       rsp_done,
    input logic       lcd_cs_n,
    input logic       lcd_rs,
    input logic       lcd_e,
    input logic       lcd_rw,
    input logic       lcd_wr_n,
    input logic       lcd_rd_n,
    input logic [7:0] lcd_db_o,
    input logic       lcd_db_oe
);
    logic any_strobe;
    assign any_strobe = lcd_e || !lcd_wr_n || !lcd_rd_n;

    a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lcd_e, !lcd_wr_n, !lcd_rd_n}));

    a_r1_enable_style: assert property (@(posedge clk) disable iff (!rst_n)
        mode_6800 |-> (lcd_wr_n && lcd_rd_n));

    a_r1_strobe_style: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_6800 |-> (!lcd_e && lcd_rw));

    a_r2_rs_steady: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |-> $stable(lcd_rs));

    a_r3_strobe_selected: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |-> (!lcd_cs_n && $past(!lcd_cs_n)));

    a_r8_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_rd_n || (lcd_e && lcd_rw)) |-> !lcd_db_oe);

    a_r8_drive_selected: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_db_oe |-> !lcd_cs_n);

    a_r6_low_lanes_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (nibble_mode && lcd_db_oe) |-> (lcd_db_o[3:0] == 4'h0));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_cs_n || rsp_done) |-> !req_ready);
endmodule

bind lcd_pbus_master lcd_pbus_master_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_6800   (mode_6800),
    .nibble_mode (nibble_mode),
    .req_ready   (req_ready),
    .rsp_done    (rsp_done),
    .lcd_cs_n    (lcd_cs_n),
    .lcd_rs      (lcd_rs),
    .lcd_e       (lcd_e),
    .lcd_rw      (lcd_rw),
    .lcd_wr_n    (lcd_wr_n),
    .lcd_rd_n    (lcd_rd_n),
    .lcd_db_o    (lcd_db_o),
    .lcd_db_oe   (lcd_db_oe)
);

// File: tb/lcd_pbus_master_test.sv
module lcd_pbus_master_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_6800 = 1'b1;
    logic       nibble_mode = 1'b0;
    logic [7:0] t_setup = 8'd2;
    logic [7:0] t_pulse = 8'd3;
    logic [7:0] t_hold = 8'd2;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_read = 1'b0;
    logic       req_rs = 1'b0;
    logic [7:0] req_wdata = 8'h00;
    logic       rsp_done;
    logic [7:0] rsp_rdata;
    logic       lcd_cs_n, lcd_rs, lcd_e, lcd_rw, lcd_wr_n, lcd_rd_n, lcd_db_oe;
    logic [7:0] lcd_db_o;
    logic [7:0] lcd_db_i = 8'h00;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    lcd_pbus_master #(.CNT_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .mode_6800(mode_6800), .nibble_mode(nibble_mode),
        .t_setup(t_setup), .t_pulse(t_pulse), .t_hold(t_hold),
        .req_valid(req_valid), .req_ready(req_ready), .req_read(req_read),
        .req_rs(req_rs), .req_wdata(req_wdata), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .lcd_cs_n(lcd_cs_n), .lcd_rs(lcd_rs),
        .lcd_e(lcd_e), .lcd_rw(lcd_rw), .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n),
        .lcd_db_o(lcd_db_o), .lcd_db_oe(lcd_db_oe), .lcd_db_i(lcd_db_i)
    );

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int eff(input logic [7:0] v);
        return (v == 8'd0) ? 1 : int'(v);
    endfunction

    // Runs one transfer and checks all pin-level results.
    task automatic xfer(input logic rd, input logic rs, input logic [7:0] wd,
                        input logic [7:0] rin, input bit poke);
        int s = eff(t_setup);
        int p = eff(t_pulse);
        int h = eff(t_hold);
        int b = nibble_mode ? 2 : 1;
        int idx = 0, done_at = 0, first_stb = 0;
        int cs_cnt = 0, stb_cnt = 0, oe_cnt = 0, rs_bad = 0, pin_bad = 0;
        int beat = 0;
        bit prev_stb = 0, stb;
        logic [7:0] cap [2];
        logic [7:0] got_rd = 8'h00;
        cap[0] = 8'h00; cap[1] = 8'h00;
        @(negedge clk);
        req_valid = 1'b1; req_read = rd; req_rs = rs; req_wdata = wd;
        lcd_db_i = nibble_mode ? {rin[7:4], 4'h0} : rin;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            idx++;
            if (poke && idx == 2) begin
                req_valid = 1'b1; req_wdata = ~wd; req_read = !rd; req_rs = !rs;
            end
            stb = mode_6800 ? lcd_e : (!lcd_wr_n || !lcd_rd_n);
            if (!lcd_cs_n) begin
                cs_cnt++;
                if (lcd_rs !== rs) rs_bad++;
                if (mode_6800 && lcd_rw !== rd) pin_bad++;
            end
            if (mode_6800 && (!lcd_wr_n || !lcd_rd_n)) pin_bad++;
            if (!mode_6800 && (lcd_e || !lcd_rw)) pin_bad++;
            if (!mode_6800 && rd && !lcd_wr_n) pin_bad++;
            if (!mode_6800 && !rd && !lcd_rd_n) pin_bad++;
            if (stb) begin
                stb_cnt++;
                if (first_stb == 0) first_stb = idx;
                if (!rd && beat < 2) cap[beat] = lcd_db_oe ? lcd_db_o : 8'hEE;
            end
            if (lcd_db_oe) oe_cnt++;
            if (!lcd_db_oe && lcd_db_o !== 8'h00) pin_bad++;
            if (prev_stb && !stb) begin
                beat++;
                lcd_db_i = nibble_mode ? {rin[3:0], 4'h0} : rin;
            end
            prev_stb = stb;
            if (rsp_done) begin
                done_at = idx; got_rd = rsp_rdata;
                break;
            end
        end
        req_valid = 1'b0;
        chk("R9 done timing", done_at == b*(s+p+h)+1, done_at, b*(s+p+h)+1);
        chk("R4 setup length", first_stb == s+1, first_stb, s+1);
        chk("R4 strobe length", stb_cnt == b*p, stb_cnt, b*p);
        chk("R3 select length", cs_cnt == b*(s+p+h), cs_cnt, b*(s+p+h));
        chk("R8 drive length", oe_cnt == (rd ? 0 : b*(s+p+1)), oe_cnt, rd ? 0 : b*(s+p+1));
        chk("R2 rs held", rs_bad == 0, rs_bad, 0);
        chk("R1 strobe pins", pin_bad == 0, pin_bad, 0);
        if (rd) begin
            chk("R7 read data", got_rd === rin, got_rd, rin);
        end else if (nibble_mode) begin
            chk("R6 first nibble", cap[0] === {wd[7:4], 4'h0}, cap[0], {wd[7:4], 4'h0});
            chk("R6 second nibble", cap[1] === {wd[3:0], 4'h0}, cap[1], {wd[3:0], 4'h0});
        end else begin
            chk("R5 write byte", cap[0] === wd, cap[0], wd);
        end
        @(negedge clk);
        chk("R9 ready after done", req_ready === 1'b1 && rsp_done === 1'b0, req_ready, 1);
        chk("R3 deselect after done", lcd_cs_n === 1'b1, lcd_cs_n, 1);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 reset cs_n", lcd_cs_n === 1'b1, lcd_cs_n, 1);
        chk("R1 reset strobes", lcd_e === 1'b0 && lcd_wr_n === 1'b1 && lcd_rd_n === 1'b1,
            {lcd_e, lcd_wr_n, lcd_rd_n}, 3'b011);
        chk("R8 reset drive", lcd_db_oe === 1'b0, lcd_db_oe, 0);
        chk("R9 reset ready", req_ready === 1'b1 && rsp_done === 1'b0, {req_ready, rsp_done}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_enable_style;
        mode_6800 = 1; nibble_mode = 0; t_setup = 2; t_pulse = 3; t_hold = 2;
        xfer(1'b0, 1'b1, 8'hA5, 8'h00, 0);   // R5 write, data
        xfer(1'b1, 1'b0, 8'h00, 8'h3C, 0);   // R7 read, instruction
    endtask

    task automatic t_strobe_style;
        mode_6800 = 0; nibble_mode = 0; t_setup = 3; t_pulse = 2; t_hold = 4;
        xfer(1'b0, 1'b0, 8'h5A, 8'h00, 0);   // R1 write strobe
        xfer(1'b1, 1'b1, 8'h00, 8'hC3, 0);   // R1 read strobe
    endtask

    task automatic t_nibble;
        mode_6800 = 1; nibble_mode = 1; t_setup = 2; t_pulse = 2; t_hold = 2;
        xfer(1'b0, 1'b1, 8'h9E, 8'h00, 0);   // R6
        mode_6800 = 0;
        xfer(1'b1, 1'b1, 8'h00, 8'h71, 0);   // R7 reassembly
        xfer(1'b0, 1'b0, 8'h2B, 8'h00, 0);   // R6 separate strobes
    endtask

    task automatic t_zero_counts;
        mode_6800 = 1; nibble_mode = 0; t_setup = 0; t_pulse = 0; t_hold = 0;
        xfer(1'b0, 1'b1, 8'hF0, 8'h00, 0);   // R4 zero as one
        xfer(1'b1, 1'b0, 8'h00, 8'h0F, 0);
    endtask

    task automatic t_busy_ignore;
        mode_6800 = 0; nibble_mode = 0; t_setup = 2; t_pulse = 2; t_hold = 2;
        xfer(1'b0, 1'b1, 8'h66, 8'h00, 1);   // R9 request during transfer
        begin
            int extra = 0;
            repeat (6) begin
                @(negedge clk);
                if (!lcd_cs_n || rsp_done) extra++;
            end
            chk("R9 busy request ignored", extra == 0, extra, 0);
        end
    endtask

    initial begin
        t_reset();
        t_enable_style();
        t_strobe_style();
        t_nibble();
        t_zero_counts();
        t_busy_ignore();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule